// File: doc/BRIEF.md
# Add/Subtract Unit with Carry Flag

This block is the integer add/subtract stage of a small processor datapath. It takes two W-bit operands and a 2-bit operation code. It produces the W-bit result, the carry out of that operation and a signed overflow indication, all combinationally. A single carry flag register sits beside it. When the enable input is high, that register captures the carry out on the rising clock edge.

One adder serves all four operations. Only the second operand and the low carry-in change between them:

- **Add:** the carry-in is 0.
- **Subtract:** the second operand is inverted and the carry-in is forced to 1, which forms the two's-complement negation.
- **Add-with-carry:** the stored flag is the carry-in, so multi-word sums can be chained across cycles.
- **Ones'-complement add:** the end-around carry is a second, incrementing pass over the first sum. This avoids any combinational loop.

Top module: `addsub_carry`

## Requirements
- R1: With `op` = 2'b00 (add), `result` equals (a + b) mod 2^W and `carry_out` equals bit W of the unbounded sum a + b.
- R2: With `op` = 2'b01 (subtract), `result` equals (a - b) mod 2^W and `carry_out` is 1 exactly when a >= b as unsigned numbers (a + ~b + 1 overflowing W bits).
- R3: With `op` = 2'b10 (add-with-carry), `result` equals (a + b + F) mod 2^W and `carry_out` equals bit W of a + b + F, where F is the current value of `carry_flag`.
- R4: With `op` = 2'b11 (ones'-complement add), let T = a + b (W+1 bits). Then `result` equals (T[W-1:0] + T[W]) mod 2^W and `carry_out` equals T[W].
- R5: On a rising clock edge with `rst` low and `en` high, `carry_flag` takes the value `carry_out` had just before that edge.
- R6: On a rising clock edge with `rst` low and `en` low, `carry_flag` keeps its value.
- R7: On a rising clock edge with `rst` high, `carry_flag` becomes 0 whatever `en` is, and it reads 0 after reset.
- R8: `overflow` is 1 exactly when `a` and the effective second operand share a sign bit and the sign bit of `result` differs from it. The effective second operand is ~b for subtract and b otherwise.
- R9: `result`, `carry_out` and `overflow` follow the present inputs and flag in the same cycle, with no register in their path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the carry flag, active high |
| en | input | 1 | Enables loading of the carry flag |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 add-with-carry, 11 ones'-complement add |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of the current operation |
| overflow | output | 1 | Signed overflow of the current operation |
| carry_flag | output | 1 | Registered carry flag |

## Verification
The result, carry out and overflow are due in the same cycle the operands and code are applied. The bench drives them after a falling edge and compares them one time unit later, well before the next rising edge. The carry flag is due one rising edge after an enabled operation. The reference model therefore updates its own flag at that edge and compares it against the port on the following cycle's sample. The add-with-carry cases rely on that flag, so a wrong flag also shows up as a wrong sum one cycle later.

// File: rtl/addsub_carry.sv
module addsub_carry #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow,
  output logic         carry_flag
);
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_ADC = 2'b10;
  localparam logic [1:0] OP_OCA = 2'b11;
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   first;
  logic         wrap;
  logic [W-1:0] second;

  assign b_eff = (op == OP_SUB) ? ~b : b;

  always_comb begin
    unique case (op)
      OP_ADD:  cin = 1'b0;
      OP_SUB:  cin = 1'b1;
      OP_ADC:  cin = carry_flag;
      OP_OCA:  cin = 1'b0;
      default: cin = 1'b0;
    endcase
  end

  assign first  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign wrap   = (op == OP_OCA) & first[W];
  assign second = first[W-1:0] + {{(W-1){1'b0}}, wrap};

  assign result    = second;
  assign carry_out = first[W];
  assign overflow  = (a[MSB] == b_eff[MSB]) & (second[MSB] != a[MSB]);

  always_ff @(posedge clk) begin
    if (rst)     carry_flag <= 1'b0;
    else if (en) carry_flag <= carry_out;
  end
endmodule

module addsub_carry_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [1:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         overflow,
  input logic         carry_flag
);
  // R5
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> carry_flag == $past(carry_out));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(carry_flag));
  // R7
  flag_reset_chk: assert property (@(posedge clk)
    rst |=> !carry_flag);
  // R2
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    op == 2'b01 |-> carry_out == (a >= b));
  // R4
  end_around_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b11 && carry_out) |-> result == W'(a + b + W'(1)));
  // R8
  add_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    op == 2'b00 |-> overflow == ((a[W-1] == b[W-1]) && (result[W-1] != a[W-1])));
endmodule

bind addsub_carry addsub_carry_chk #(.W(W)) u_chk (.*);

// File: tb/sim_addsub_carry.sv
`timescale 1ns/1ps
module sim_addsub_carry;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [1:0]   op  = 2'b00;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [W-1:0] result;
  logic         carry_out, overflow, carry_flag;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  bit  mflag  = 0;

  always #2 clk = ~clk;

  addsub_carry #(.W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .op(op), .a(a), .b(b),
    .result(result), .carry_out(carry_out), .overflow(overflow),
    .carry_flag(carry_flag)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [1:0] o);
    case (o)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic step(bit r, bit e, logic [1:0] o, logic [W-1:0] x, logic [W-1:0] y);
    logic [W:0]   t;
    logic [W-1:0] er, be;
    logic         ec, eo;
    @(negedge clk);
    rst = r; en = e; op = o; a = x; b = y;
    be = (o == 2'b01) ? ~y : y;
    case (o)
      2'b00: t = {1'b0, x} + {1'b0, y};
      2'b01: t = {1'b0, x} + {1'b0, ~y} + (W+1)'(1);
      2'b10: t = {1'b0, x} + {1'b0, y} + (W+1)'(mflag);
      default: t = {1'b0, x} + {1'b0, y};
    endcase
    ec = t[W];
    er = (o == 2'b11) ? t[W-1:0] + W'(t[W]) : t[W-1:0];
    eo = (x[W-1] == be[W-1]) && (er[W-1] != x[W-1]);
    #1;
    // R9: combinational outputs sampled in the same cycle
    chk(req_of(o), "result", longint'(result), longint'(er));
    chk(req_of(o), "carry_out", longint'(carry_out), longint'(ec));
    chk("R8", "overflow", longint'(overflow), longint'(eo));
    chk(r ? "R7" : (e ? "R5" : "R6"), "carry_flag", longint'(carry_flag), longint'(mflag));
    @(posedge clk);
    if (r) mflag = 0;
    else if (e) mflag = ec;
  endtask

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  initial begin
    step(1, 0, 2'b00, '0, '0);
    step(1, 1, 2'b00, ONES, W'(1));                 // R7 reset beats enable
    chk("R7", "flag after reset", longint'(carry_flag), 0);
    // R1 wrap with carry, then R3 uses the flag
    step(0, 1, 2'b00, ONES, W'(1));
    step(0, 1, 2'b10, W'(5), W'(7));                // R3 with flag 1
    step(0, 1, 2'b10, W'(5), W'(7));                // R3 with flag 0
    // R2 equal, smaller, larger
    step(0, 1, 2'b01, W'(9), W'(9));
    step(0, 1, 2'b01, W'(3), W'(9));
    step(0, 1, 2'b01, W'(9), W'(3));
    // R6 hold with enable low
    step(0, 0, 2'b00, ONES, ONES);
    step(0, 0, 2'b10, W'(1), W'(2));
    // R4 end-around carry and none
    step(0, 1, 2'b11, ONES, W'(1));
    step(0, 1, 2'b11, ONES, ONES);
    step(0, 1, 2'b11, W'(4), W'(8));
    // R8 overflow corners
    step(0, 1, 2'b00, MAXP, W'(1));
    step(0, 1, 2'b00, MINN, MINN);
    step(0, 1, 2'b01, MINN, W'(1));
    step(0, 1, 2'b01, MAXP, ONES);
    step(0, 1, 2'b01, '0, MINN);
    step(1, 0, 2'b00, '0, '0);
    for (int i = 0; i < 2000; i++)
      step(($urandom % 50) == 0, ($urandom % 4) != 0, 2'($urandom),
           (i % 7 == 0) ? ONES : W'($urandom), (i % 11 == 0) ? MINN : W'($urandom));
    step(0, 0, 2'b00, '0, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule